// File: doc/BRIEF.md
# Serial Audio Link Control Register

This block is the control register that governs a serial audio codec link. A bus master writes it at two addresses. The set address can only turn control bits on. The clear address can only turn them off. Together the control bits drive the codec's active-low cold reset, the warm reset, the low-power forcing of the frame sync and serial data outputs, the wake-up enable and the choice of receive slot. Address 0 is the set address and address 1 is the clear address.

The block also holds one ready flag for each codec. An input pulse sets a flag, and a write-one-to-clear bit on the set address clears both flags, so software can check readiness again after it powers a codec down. Each codec serial data input passes through a synchronizer. While wake-up is enabled, a high level on any of these inputs raises a level-sensitive power-management interrupt. The outgoing frame sync and serial data pass through the block and are registered on the way out, so that low-power mode can force them low and warm reset can drive the frame sync high.

Top module: `aclink_ctl_reg`

## Requirements
- R1: A synchronous reset clears every control bit and ready flag. After reset, codec_rst_n, warm_rst, mic_sel, wake_irq, sync_out and sdout_out are 0 and rd_data reads 0x00.
- R2: A write to address 0 sets each control bit (bits 4:0) whose data bit is 1 and leaves the other control bits unchanged. rd_data[4:0] shows the control bits after the write edge, at either address.
- R3: A write to address 1 clears each control bit (bits 4:0) whose data bit is 1 and leaves the other control bits unchanged. Data bits 7:5 at address 1 have no effect.
- R4: codec_rst_n is high exactly when control bit 0 (link enable) is 1.
- R5: While control bit 1 (low power) is 1, sync_out and sdout_out are 0 one cycle later. While it is 0, they follow sync_in and sdout_in with one cycle of delay.
- R6: While control bit 3 (warm reset) is 1, warm_rst is 1 and sync_out is 1 one cycle later, even when low power is set.
- R7: mic_sel equals control bit 4. A 0 selects stereo slots 3 and 4 for receive, and a 1 selects the microphone slot 6.
- R8: Writing 1 to bit 5 at address 0 clears both ready flags. Bit 5 always reads 0.
- R9: A pulse on rdy_pulse[i] sets codec_rdy[i] at the next edge. If a pulse arrives in the same cycle as a bit-5 clear, the set wins.
- R10: Bits 7:6 read as 0 and ignore writes at either address.
- R11: wake_irq is 1 when control bit 2 (wake-up enable) is 1 and any synchronized sdin line is 1. A rise on sdin reaches wake_irq three edges later, and clearing the enable drops wake_irq one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 1 | 0 = set address, 1 = clear address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Readback of control bits |
| rdy_pulse | input | NUM_CODEC | Codec-ready set pulses |
| codec_rdy | output | NUM_CODEC | Codec-ready flags |
| sdin | input | NUM_SDIN | Asynchronous codec data-in lines |
| sync_in | input | 1 | Frame sync from the serializer |
| sdout_in | input | 1 | Serial data from the serializer |
| sync_out | output | 1 | Gated frame sync to the link |
| sdout_out | output | 1 | Gated serial data to the link |
| codec_rst_n | output | 1 | Active-low codec cold reset |
| warm_rst | output | 1 | Warm reset condition |
| mic_sel | output | 1 | Receive slot select |
| wake_irq | output | 1 | Wake-up interrupt request |

## Verification
The properties assume that reset is held for at least one edge before any write. They also assume a single write strobe per cycle, directed at one address, and sdin lines that hold each level for several cycles so that a wake-up decision can be traced through the synchronizer. The stimulus writes only between clock edges and never overlaps two writes. It holds every sdin level for at least four cycles. It drives the ready pulses for one cycle, and at one point it aligns a pulse on purpose with a clear write to check the priority rule.

// File: rtl/aclink_pkg.sv
package aclink_pkg;
  localparam int REG_W      = 8;
  localparam int CTL_W      = 5;
  localparam int BIT_RDYCLR = 5;

  typedef struct packed {
    logic mic;
    logic warm;
    logic wake;
    logic lowpwr;
    logic link;
  } ctl_t;
endpackage

// File: rtl/aclink_ctl_bits.sv
module aclink_ctl_bits #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_mask,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)              q[i] <= 1'b0;
      else if (set_mask[i]) q[i] <= 1'b1;
      else if (clr_mask[i]) q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/aclink_rdy_flags.sv
module aclink_rdy_flags #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pulse,
  input  logic         clr_all,
  output logic [N-1:0] flags
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    // set wins over a simultaneous clear
    always_ff @(posedge clk) begin
      if (rst)           flags[i] <= 1'b0;
      else if (pulse[i]) flags[i] <= 1'b1;
      else if (clr_all)  flags[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/aclink_sdin_sync.sv
module aclink_sdin_sync #(
  parameter int N      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_line
    logic [STAGES-1:0] sh;
    always_ff @(posedge clk) begin
      if (rst) sh <= '0;
      else     sh <= {sh[STAGES-2:0], d[i]};
    end
    assign q[i] = sh[STAGES-1];
  end
endmodule

// File: rtl/aclink_link_gate.sv
module aclink_link_gate #(
  parameter int N = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  aclink_pkg::ctl_t ctl,
  input  logic             sync_in,
  input  logic             sdout_in,
  input  logic [N-1:0]     sdin_s,
  output logic             sync_out,
  output logic             sdout_out,
  output logic             wake_irq
);
  logic sync_nxt, sdout_nxt, irq_nxt;

  always_comb begin
    if (ctl.warm)        sync_nxt = 1'b1;
    else if (ctl.lowpwr) sync_nxt = 1'b0;
    else                 sync_nxt = sync_in;
    sdout_nxt = ctl.lowpwr ? 1'b0 : sdout_in;
    irq_nxt   = ctl.wake & (|sdin_s);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_out  <= 1'b0;
      sdout_out <= 1'b0;
      wake_irq  <= 1'b0;
    end else begin
      sync_out  <= sync_nxt;
      sdout_out <= sdout_nxt;
      wake_irq  <= irq_nxt;
    end
  end
endmodule

// File: rtl/aclink_ctl_reg.sv
module aclink_ctl_reg #(
  parameter int NUM_CODEC   = 2,
  parameter int NUM_SDIN    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic                         wr_addr,
  input  logic [aclink_pkg::REG_W-1:0] wr_data,
  output logic [aclink_pkg::REG_W-1:0] rd_data,
  input  logic [NUM_CODEC-1:0]         rdy_pulse,
  output logic [NUM_CODEC-1:0]         codec_rdy,
  input  logic [NUM_SDIN-1:0]          sdin,
  input  logic                         sync_in,
  input  logic                         sdout_in,
  output logic                         sync_out,
  output logic                         sdout_out,
  output logic                         codec_rst_n,
  output logic                         warm_rst,
  output logic                         mic_sel,
  output logic                         wake_irq
);
  import aclink_pkg::*;

  localparam int PAD_W = REG_W - CTL_W;

  logic             set_sel, clr_sel, rdy_clr;
  logic [CTL_W-1:0] set_mask, clr_mask, ctl_q;
  logic [NUM_SDIN-1:0] sdin_s;
  ctl_t             ctl;

  assign set_sel  = wr_en & ~wr_addr;
  assign clr_sel  = wr_en &  wr_addr;
  assign set_mask = {CTL_W{set_sel}} & wr_data[CTL_W-1:0];
  assign clr_mask = {CTL_W{clr_sel}} & wr_data[CTL_W-1:0];
  assign rdy_clr  = set_sel & wr_data[BIT_RDYCLR];

  aclink_ctl_bits #(.W(CTL_W)) u_bits (
    .clk(clk), .rst(rst), .set_mask(set_mask), .clr_mask(clr_mask), .q(ctl_q)
  );

  aclink_rdy_flags #(.N(NUM_CODEC)) u_rdy (
    .clk(clk), .rst(rst), .pulse(rdy_pulse), .clr_all(rdy_clr), .flags(codec_rdy)
  );

  aclink_sdin_sync #(.N(NUM_SDIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(sdin), .q(sdin_s)
  );

  assign ctl = ctl_t'(ctl_q);

  aclink_link_gate #(.N(NUM_SDIN)) u_gate (
    .clk(clk), .rst(rst), .ctl(ctl), .sync_in(sync_in), .sdout_in(sdout_in),
    .sdin_s(sdin_s), .sync_out(sync_out), .sdout_out(sdout_out), .wake_irq(wake_irq)
  );

  assign rd_data     = {{PAD_W{1'b0}}, ctl_q};
  assign codec_rst_n = ctl.link;
  assign warm_rst    = ctl.warm;
  assign mic_sel     = ctl.mic;
endmodule

// File: rtl/aclink_ctl_reg_chk.sv
module aclink_ctl_reg_chk #(
  parameter int NUM_CODEC = 2
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 wr_en,
  input logic                 wr_addr,
  input logic [7:0]           wr_data,
  input logic [7:0]           rd_data,
  input logic [NUM_CODEC-1:0] rdy_pulse,
  input logic [NUM_CODEC-1:0] codec_rdy,
  input logic                 sync_out,
  input logic                 sdout_out,
  input logic                 codec_rst_n,
  input logic                 mic_sel,
  input logic                 wake_irq
);
  p_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!codec_rst_n && rd_data == 8'h00 && !wake_irq));

  p_set_link_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_addr && wr_data[0]) |=> codec_rst_n);

  p_clr_mic_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr && wr_data[4]) |=> !mic_sel);

  p_lowpwr_r5: assert property (@(posedge clk) disable iff (rst)
    rd_data[1] |=> !sdout_out);

  p_warm_sync_r6: assert property (@(posedge clk) disable iff (rst)
    rd_data[3] |=> sync_out);

  p_rdy_set_r9: assert property (@(posedge clk) disable iff (rst)
    rdy_pulse[0] |=> codec_rdy[0]);

  p_reserved_r10: assert property (@(posedge clk) disable iff (rst)
    rd_data[7:5] == 3'b000);

  p_irq_needs_wake_r11: assert property (@(posedge clk) disable iff (rst)
    wake_irq |-> $past(rd_data[2]));
endmodule

bind aclink_ctl_reg aclink_ctl_reg_chk #(.NUM_CODEC(NUM_CODEC)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .rd_data(rd_data), .rdy_pulse(rdy_pulse), .codec_rdy(codec_rdy),
  .sync_out(sync_out), .sdout_out(sdout_out), .codec_rst_n(codec_rst_n),
  .mic_sel(mic_sel), .wake_irq(wake_irq)
);

// File: tb/aclink_ctl_reg_bench.sv
module aclink_ctl_reg_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, wr_addr = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic [1:0] rdy_pulse = 2'b00, codec_rdy;
  logic [1:0] sdin = 2'b00;
  logic       sync_in = 1'b0, sdout_in = 1'b0;
  logic       sync_out, sdout_out, codec_rst_n, warm_rst, mic_sel, wake_irq;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  aclink_ctl_reg u_aclink_ctl_reg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_data(rd_data), .rdy_pulse(rdy_pulse), .codec_rdy(codec_rdy), .sdin(sdin),
    .sync_in(sync_in), .sdout_in(sdout_in), .sync_out(sync_out), .sdout_out(sdout_out),
    .codec_rst_n(codec_rst_n), .warm_rst(warm_rst), .mic_sel(mic_sel), .wake_irq(wake_irq)
  );

  // {addr, data, expected readback}
  localparam logic [16:0] VEC [0:8] = '{
    {1'b0, 8'h01, 8'h01},  // R2 set link
    {1'b0, 8'h10, 8'h11},  // R2 set mic, keep link
    {1'b0, 8'h00, 8'h11},  // R2 zero write no effect
    {1'b0, 8'hC0, 8'h11},  // R10 reserved ignored
    {1'b1, 8'h01, 8'h10},  // R3 clear link only
    {1'b0, 8'h0E, 8'h1E},  // R2 set three bits
    {1'b1, 8'hE0, 8'h1E},  // R3 upper bits at clear address ignored
    {1'b1, 8'hFF, 8'h00},  // R3 clear all
    {1'b0, 8'h20, 8'h00}   // R8 bit 5 reads zero
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    sync_in = 1'b1; sdout_in = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 rd_data", rd_data, 8'h00);
    chk("R1 outputs", {2'b0, codec_rst_n, warm_rst, mic_sel, wake_irq, sync_out, sdout_out}, 8'h00);
    chk("R1 codec_rdy", {6'b0, codec_rdy}, 8'h00);
    rst = 1'b0;

    for (int i = 0; i < 9; i++) begin
      wr(VEC[i][16], VEC[i][15:8]);
      chk($sformatf("R2/R3/R8/R10 vector %0d", i), rd_data, VEC[i][7:0]);
    end

    // R4 cold reset follows link enable
    wr(1'b0, 8'h01);
    chk("R4 codec_rst_n high", {7'b0, codec_rst_n}, 8'h01);
    wr(1'b1, 8'h01);
    chk("R4 codec_rst_n low", {7'b0, codec_rst_n}, 8'h00);

    // R5 pass-through then forced low
    @(negedge clk);
    chk("R5 pass-through", {6'b0, sync_out, sdout_out}, 8'h03);
    wr(1'b0, 8'h02);
    @(negedge clk);
    chk("R5 low power forces low", {6'b0, sync_out, sdout_out}, 8'h00);

    // R6 warm reset overrides low power on sync
    wr(1'b0, 8'h08);
    chk("R6 warm_rst", {7'b0, warm_rst}, 8'h01);
    @(negedge clk);
    chk("R6 sync high, sdout low", {6'b0, sync_out, sdout_out}, 8'h02);
    wr(1'b1, 8'h0A);
    @(negedge clk);
    chk("R5 released pass-through", {6'b0, sync_out, sdout_out}, 8'h03);

    // R7 receive slot select
    wr(1'b0, 8'h10);
    chk("R7 mic_sel set", {7'b0, mic_sel}, 8'h01);
    wr(1'b1, 8'h10);
    chk("R7 mic_sel clear", {7'b0, mic_sel}, 8'h00);

    // R9 / R8 ready flags
    @(negedge clk); rdy_pulse = 2'b11;
    @(negedge clk); rdy_pulse = 2'b00;
    chk("R9 flags set", {6'b0, codec_rdy}, 8'h03);
    wr(1'b1, 8'h20);
    chk("R3 bit5 at clear addr ignored", {6'b0, codec_rdy}, 8'h03);
    wr(1'b0, 8'h20);
    chk("R8 flags cleared", {6'b0, codec_rdy}, 8'h00);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 1'b0; wr_data = 8'h20; rdy_pulse = 2'b01;
    @(negedge clk);
    wr_en = 1'b0; rdy_pulse = 2'b00;
    chk("R9 set beats clear", {6'b0, codec_rdy}, 8'h01);

    // R11 wake interrupt
    sdin = 2'b10;
    repeat (4) @(negedge clk);
    chk("R11 no irq when disabled", {7'b0, wake_irq}, 8'h00);
    wr(1'b0, 8'h04);
    repeat (2) @(negedge clk);
    chk("R11 irq with high sdin", {7'b0, wake_irq}, 8'h01);
    wr(1'b1, 8'h04);
    @(negedge clk);
    chk("R11 irq drops on disable", {7'b0, wake_irq}, 8'h00);
    wr(1'b0, 8'h04);
    sdin = 2'b00;
    repeat (4) @(negedge clk);
    chk("R11 irq low with sdin low", {7'b0, wake_irq}, 8'h00);
    sdin = 2'b01;
    repeat (2) @(negedge clk);
    chk("R11 latency not yet", {7'b0, wake_irq}, 8'h00);
    @(negedge clk);
    chk("R11 irq after three edges", {7'b0, wake_irq}, 8'h01);

    // R1 reset mid-run
    rst = 1'b1;
    @(negedge clk);
    chk("R1 reset clears", rd_data, 8'h00);
    chk("R1 reset irq", {7'b0, wake_irq}, 8'h00);
    rst = 1'b0;
    finish_run();
  end
endmodule